// File: doc/BRIEF.md
# OSD Character Display Memory Writer

This block owns the character memory of an on-screen-display overlay. The memory has 480 cells, and each cell holds an 8-bit character index and a 3-bit attribute (local background, blink, invert). Cell 0 is the upper-left character position. NTSC uses 13 visible rows and PAL uses 16. A host writes four byte-wide registers through a strobe interface: a mode register, the high and low parts of a 9-bit cell pointer, and a data-in port. A registered lookup port lets the pixel side fetch any cell.

A state machine sets how a data-in write is handled. It has three states:

- `ST_MANUAL`: a data-in write stores to the addressed cell and leaves the pointer where it is.
- `ST_AUTO`: each data-in write stores the character with the current attribute, then advances the pointer. The code 0xFF is never stored in this state. It is the terminator and returns the machine to `ST_MANUAL`.
- `ST_CLEAR`: the machine writes zero into every cell, one cell per clock cycle.

The transitions are these:

- Reset enters `ST_CLEAR`.
- A mode write with the clear bit set goes to `ST_CLEAR`.
- A mode write with the clear bit clear goes to `ST_AUTO` or `ST_MANUAL`, following the auto bit.
- A 0xFF data-in write in `ST_AUTO` goes to `ST_MANUAL`.
- The last cell of a clear goes to `ST_MANUAL`.

Because 0xFF ends auto-increment, software that needs a literal 0xFF in a cell must write it in `ST_MANUAL`.

Top module: `osd_dm_writer`

## Requirements
- R1: Reset starts a clear of the whole memory. The mode register reads 0x04 from the first cycle after reset release for 480 cycles, then reads 0x00. The pointer reads 0.
- R2: The register select codes are 0 = mode, 1 = pointer high, 2 = pointer low, 3 = data-in. Pointer high bit 0 supplies pointer bit 8, and pointer low supplies bits 7:0. Reading pointer high returns {7'b0, bit 8}.
- R3: Mode bit positions are: bit 6 = 8-bit mode, bits 5:3 = attribute, bit 2 = clear, bit 0 = auto-increment. Bits 7 and 1 are ignored on write and read as 0. The clear bit reads 1 only while a clear runs.
- R4: In `ST_AUTO` in 16-bit mode, a data-in byte other than 0xFF stores the byte as the character and mode bits 5:3 as the attribute, and the pointer then advances by one.
- R5: In `ST_AUTO`, a data-in byte of 0xFF stores nothing, leaves the pointer unchanged, and moves to `ST_MANUAL`. From then on the auto bit reads 0.
- R6: In `ST_MANUAL`, a data-in write stores to the addressed cell, including the value 0xFF, and the pointer does not move.
- R7: In `ST_AUTO` at pointer 479, a write stores to cell 479. The pointer stays at 479 and does not wrap.
- R8: A mode write with bit 2 set zeroes all 480 cells, one per cycle, and the clear bit reads 1 for exactly 480 cycles. Register writes during a clear are ignored. After the clear the state is `ST_MANUAL`, with the attribute and 8-bit fields taken from that mode write.
- R9: In 8-bit mode, a data-in write replaces only the character byte. The cell keeps its stored attribute.
- R10: A data-in write while the pointer is 480 or above stores nothing, and in `ST_AUTO` it does not advance the pointer.
- R11: The lookup port returns the cell chosen by `look_idx` one clock later. An index of 480 or above returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 2 | Register select for readback |
| rd_data | output | 8 | Combinational register readback |
| look_idx | input | 9 | Cell index for the lookup port |
| look_char | output | 8 | Character index of the looked-up cell |
| look_attr | output | 3 | Attribute of the looked-up cell |

## Verification
A wrong state shows at the mode readback on the very next cycle:

- A missed terminator leaves the auto bit at 1.
- A clear that ends early or late shows up in the count of cycles with the clear bit set.

A wrong pointer shows as a bad pointer readback straight after the write. It also shows as a character that lands in the wrong cell, which the lookup port exposes one cycle after the index is presented. Cells beyond the ones written are looked up as well, so a store that goes astray or aliases is also seen.

// File: rtl/osd_dm_pkg.sv
package osd_dm_pkg;

    typedef enum logic [1:0] {
        ST_MANUAL = 2'd0,
        ST_AUTO   = 2'd1,
        ST_CLEAR  = 2'd2
    } dm_state_e;

    typedef enum logic [1:0] {
        SEL_MODE    = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_DATA_IN = 2'd3
    } reg_sel_e;

    localparam int MODE_AUTO_BIT  = 0;
    localparam int MODE_CLEAR_BIT = 2;
    localparam int MODE_ATTR_LSB  = 3;
    localparam int MODE_NARROW_BIT = 6;
    localparam logic [7:0] TERM_CODE = 8'hFF;

endpackage

// File: rtl/osd_dm_ctrl.sv
module osd_dm_ctrl
    import osd_dm_pkg::*;
#(
    parameter int ENTRIES = 480,
    parameter int ATTR_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    output dm_state_e         state_o,
    output logic [IDX_W-1:0]  addr_o,
    output logic              narrow_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [7:0]        mem_char,
    output logic [ATTR_W-1:0] mem_attr,
    output logic              mem_keep_attr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    dm_state_e         state, state_n;
    logic [IDX_W-1:0]  addr, addr_n;
    logic [IDX_W-1:0]  clr_idx, clr_idx_n;
    logic              narrow, narrow_n;
    logic [ATTR_W-1:0] attr, attr_n;

    logic din_wr;
    logic in_range;
    logic is_term;

    assign din_wr   = wr_en && (wr_sel == SEL_DATA_IN);
    assign in_range = (addr <= LAST);
    assign is_term  = (wr_data == TERM_CODE);

    // next-state and register update decode
    always_comb begin
        state_n   = state;
        addr_n    = addr;
        clr_idx_n = clr_idx;
        narrow_n  = narrow;
        attr_n    = attr;
        unique case (state)
            ST_CLEAR: begin
                if (clr_idx == LAST) begin
                    state_n = ST_MANUAL;
                end else begin
                    clr_idx_n = clr_idx + 1'b1;
                end
            end
            ST_MANUAL, ST_AUTO: begin
                if (wr_en) begin
                    unique case (wr_sel)
                        SEL_MODE: begin
                            narrow_n = wr_data[MODE_NARROW_BIT];
                            attr_n   = wr_data[MODE_ATTR_LSB +: ATTR_W];
                            if (wr_data[MODE_CLEAR_BIT]) begin
                                state_n   = ST_CLEAR;
                                clr_idx_n = '0;
                            end else if (wr_data[MODE_AUTO_BIT]) begin
                                state_n = ST_AUTO;
                            end else begin
                                state_n = ST_MANUAL;
                            end
                        end
                        SEL_ADDR_HI: addr_n[IDX_W-1:8] = wr_data[IDX_W-9:0];
                        SEL_ADDR_LO: addr_n[7:0] = wr_data;
                        SEL_DATA_IN: begin
                            if (state == ST_AUTO) begin
                                if (is_term) begin
                                    state_n = ST_MANUAL;
                                end else if (in_range && (addr != LAST)) begin
                                    addr_n = addr + 1'b1;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: state_n = ST_MANUAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            addr    <= '0;
            clr_idx <= '0;
            narrow  <= 1'b0;
            attr    <= '0;
        end else begin
            state   <= state_n;
            addr    <= addr_n;
            clr_idx <= clr_idx_n;
            narrow  <= narrow_n;
            attr    <= attr_n;
        end
    end

    // memory write port outputs
    always_comb begin
        mem_we        = 1'b0;
        mem_idx       = addr;
        mem_char      = wr_data;
        mem_attr      = attr;
        mem_keep_attr = narrow;
        unique case (state)
            ST_CLEAR: begin
                mem_we        = 1'b1;
                mem_idx       = clr_idx;
                mem_char      = '0;
                mem_attr      = '0;
                mem_keep_attr = 1'b0;
            end
            ST_AUTO:   mem_we = din_wr && in_range && !is_term;
            ST_MANUAL: mem_we = din_wr && in_range;
            default:   mem_we = 1'b0;
        endcase
    end

    assign state_o  = state;
    assign addr_o   = addr;
    assign narrow_o = narrow;
    assign attr_o   = attr;

    // R4
    auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTO && din_wr && !is_term && addr < LAST) |=> (addr == $past(addr) + 1'b1));

    // R5
    term_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTO && din_wr && is_term) |=> (state == ST_MANUAL && $stable(addr)));

    // R6
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL && din_wr) |=> (state == ST_MANUAL && $stable(addr)));

    // R7
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTO && din_wr && addr == LAST) |=> (addr == LAST));

    // R8
    clear_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && clr_idx != LAST) |=> (state == ST_CLEAR && clr_idx == $past(clr_idx) + 1'b1));

    // R8
    clear_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && clr_idx == LAST) |=> (state == ST_MANUAL));

endmodule

// File: rtl/osd_dm_store.sv
module osd_dm_store #(
    parameter int ENTRIES = 480,
    parameter int ATTR_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        wchar,
    input  logic [ATTR_W-1:0] wattr,
    input  logic              keep_attr,
    input  logic [IDX_W-1:0]  look_idx,
    output logic [7:0]        look_char,
    output logic [ATTR_W-1:0] look_attr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [7:0]        char_mem [ENTRIES];
    logic [ATTR_W-1:0] attr_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we && idx <= LAST) begin
            char_mem[idx] <= wchar;
            if (!keep_attr) begin
                attr_mem[idx] <= wattr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            look_char <= '0;
            look_attr <= '0;
        end else if (look_idx <= LAST) begin
            look_char <= char_mem[look_idx];
            look_attr <= attr_mem[look_idx];
        end else begin
            look_char <= '0;
            look_attr <= '0;
        end
    end

    // R10
    store_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (idx <= LAST));

endmodule

// File: rtl/osd_dm_readback.sv
module osd_dm_readback
    import osd_dm_pkg::*;
#(
    parameter int ENTRIES = 480,
    parameter int ATTR_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [1:0]        rd_sel,
    input  dm_state_e         state,
    input  logic [IDX_W-1:0]  addr,
    input  logic              narrow,
    input  logic [ATTR_W-1:0] attr,
    output logic [7:0]        rd_data
);

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_MODE: begin
                rd_data[MODE_NARROW_BIT]              = narrow;
                rd_data[MODE_ATTR_LSB +: ATTR_W]      = attr;
                rd_data[MODE_CLEAR_BIT]               = (state == ST_CLEAR);
                rd_data[MODE_AUTO_BIT]                = (state == ST_AUTO);
            end
            SEL_ADDR_HI: rd_data = 8'(addr >> 8);
            SEL_ADDR_LO: rd_data = addr[7:0];
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/osd_dm_writer.sv
module osd_dm_writer
    import osd_dm_pkg::*;
#(
    parameter int ENTRIES = 480,
    parameter int ATTR_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_sel,
    output logic [7:0]        rd_data,
    input  logic [IDX_W-1:0]  look_idx,
    output logic [7:0]        look_char,
    output logic [ATTR_W-1:0] look_attr
);

    dm_state_e         state;
    logic [IDX_W-1:0]  addr;
    logic              narrow;
    logic [ATTR_W-1:0] attr;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [7:0]        mem_char;
    logic [ATTR_W-1:0] mem_attr;
    logic              mem_keep_attr;

    osd_dm_ctrl #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .state_o(state), .addr_o(addr), .narrow_o(narrow), .attr_o(attr),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_char(mem_char),
        .mem_attr(mem_attr), .mem_keep_attr(mem_keep_attr)
    );

    osd_dm_store #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .idx(mem_idx), .wchar(mem_char), .wattr(mem_attr),
        .keep_attr(mem_keep_attr),
        .look_idx(look_idx), .look_char(look_char), .look_attr(look_attr)
    );

    osd_dm_readback #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W)) rb_i (
        .rd_sel(rd_sel), .state(state), .addr(addr),
        .narrow(narrow), .attr(attr), .rd_data(rd_data)
    );

endmodule

// File: tb/osd_dm_writer_tb.sv
module osd_dm_writer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic [8:0] look_idx = '0;
    logic [7:0] look_char;
    logic [2:0] look_attr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    osd_dm_writer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .look_idx(look_idx), .look_char(look_char), .look_attr(look_attr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic look(input int idx, output logic [7:0] c, output logic [2:0] a);
        @(negedge clk);
        look_idx = 9'(idx);
        @(negedge clk);
        c = look_char;
        a = look_attr;
    endtask

    task automatic set_ptr(input int p);
        reg_wr(2'd1, 8'(p >> 8));
        reg_wr(2'd2, 8'(p));
    endtask

    task automatic t_reset();
        logic [7:0] v; logic [7:0] c; logic [2:0] a; int n;
        reg_rd(2'd0, v);
        chk("R1 mode during reset clear", v, 8'h04);
        n = 0;
        while (n < 1000) begin
            reg_rd(2'd0, v);
            if (!v[2]) break;
            n++;
            @(negedge clk);
        end
        chk("R1 reset clear cycles", n, 480);
        reg_rd(2'd0, v); chk("R1 mode after reset clear", v, 8'h00);
        reg_rd(2'd2, v); chk("R1 pointer after reset", v, 8'h00);
        look(479, c, a); chk("R1 cell 479 zero", {a, c}, 0);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        set_ptr(300);
        reg_rd(2'd1, v); chk("R2 pointer high", v, 8'h01);
        reg_rd(2'd2, v); chk("R2 pointer low", v, 8'h2C);
        reg_wr(2'd1, 8'hFE);
        reg_rd(2'd1, v); chk("R2 high uses bit0 only", v, 8'h00);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        reg_wr(2'd0, 8'h28); reg_rd(2'd0, v); chk("R3 mode attr", v, 8'h28);
        reg_wr(2'd0, 8'h69); reg_rd(2'd0, v); chk("R3 mode narrow+auto", v, 8'h69);
        reg_wr(2'd0, 8'hAA); reg_rd(2'd0, v); chk("R3 mode ignored bits", v, 8'h28);
    endtask

    task automatic t_auto();
        logic [7:0] v; logic [7:0] c; logic [2:0] a;
        reg_wr(2'd0, 8'h19);
        set_ptr(10);
        reg_wr(2'd3, 8'h41); reg_wr(2'd3, 8'h42); reg_wr(2'd3, 8'h43);
        reg_rd(2'd2, v); chk("R4 pointer advanced", v, 8'd13);
        look(10, c, a); chk("R4 cell 10", {a, c}, {3'd3, 8'h41});
        look(12, c, a); chk("R4 cell 12", {a, c}, {3'd3, 8'h43});
    endtask

    task automatic t_term();
        logic [7:0] v; logic [7:0] c; logic [2:0] a;
        reg_wr(2'd3, 8'hFF);
        reg_rd(2'd0, v); chk("R5 auto bit cleared", v, 8'h18);
        reg_rd(2'd2, v); chk("R5 pointer unchanged", v, 8'd13);
        look(13, c, a); chk("R5 cell 13 untouched", {a, c}, 0);
        reg_wr(2'd3, 8'h55);
        reg_rd(2'd2, v); chk("R6 manual no advance", v, 8'd13);
        look(13, c, a); chk("R6 manual store", {a, c}, {3'd3, 8'h55});
        reg_wr(2'd3, 8'hFF);
        look(13, c, a); chk("R6 manual stores 0xFF", {a, c}, {3'd3, 8'hFF});
    endtask

    task automatic t_last();
        logic [7:0] v; logic [7:0] c; logic [2:0] a;
        reg_wr(2'd0, 8'h01);
        set_ptr(478);
        reg_wr(2'd3, 8'h10); reg_wr(2'd3, 8'h11); reg_wr(2'd3, 8'h12);
        reg_rd(2'd1, v); chk("R7 pointer high at end", v, 8'h01);
        reg_rd(2'd2, v); chk("R7 pointer low at end", v, 8'hDF);
        look(478, c, a); chk("R7 cell 478", c, 8'h10);
        look(479, c, a); chk("R7 cell 479 overwritten", c, 8'h12);
        look(0, c, a); chk("R7 no wrap to cell 0", c, 8'h00);
    endtask

    task automatic t_narrow();
        logic [7:0] c; logic [2:0] a;
        reg_wr(2'd0, 8'h68);
        set_ptr(10);
        reg_wr(2'd3, 8'h77);
        look(10, c, a); chk("R9 narrow keeps attr", {a, c}, {3'd3, 8'h77});
    endtask

    task automatic t_range();
        logic [7:0] v; logic [7:0] c; logic [2:0] a;
        reg_wr(2'd0, 8'h01);
        set_ptr(490);
        reg_wr(2'd3, 8'h33);
        reg_rd(2'd2, v); chk("R10 out-of-range no advance", v, 8'hEA);
        look(490, c, a); chk("R11 out-of-range lookup zero", {a, c}, 0);
        look(479, c, a); chk("R10 no alias store", c, 8'h12);
    endtask

    task automatic t_clear();
        logic [7:0] v; logic [7:0] c; logic [2:0] a; int n;
        reg_wr(2'd0, 8'h2D);
        n = 0;
        while (n < 1000) begin
            reg_rd(2'd0, v);
            if (!v[2]) break;
            n++;
            if (n == 5) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h05; end
            if (n == 6) wr_en = 1'b0;
            @(negedge clk);
        end
        chk("R8 clear cycles", n, 480);
        reg_rd(2'd0, v); chk("R8 mode after clear", v, 8'h28);
        reg_rd(2'd2, v); chk("R8 write during clear ignored", v, 8'hEA);
        look(10, c, a);  chk("R8 cell 10 cleared", {a, c}, 0);
        look(479, c, a); chk("R8 cell 479 cleared", {a, c}, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_mode();
        t_auto();
        t_term();
        t_last();
        t_narrow();
        t_range();
        t_clear();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule